// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block generates raster timing for a digital video transmitter. The frame geometry is programmed at run time instead of being fixed when the design is built. The programmed values are the total frame width and height, the active picture width and height, and the start, width and polarity of each sync pulse. The block walks a horizontal and a vertical position counter through the frame. From them it drives hsync, vsync and a data-enable, and it gates the incoming pixel bus so that blanked pixels leave as zero.

Blanking comes first. The left columns of each line and the top rows of each frame are blanking, and the active picture sits in the bottom-right corner. On every active row, two strobes mark the cycles just before the first active pixel: an 8-cycle preamble window followed by a 2-cycle guard window. A transmitter uses them to insert its control periods. The block also drives the pixel position inside the active picture, so a pixel source can address a line buffer.

New configuration values are sampled into shadow registers, and only at reset or when the counters return to the frame origin. The frame in progress therefore keeps its geometry. An enable input freezes the raster, and a synchronous reset restarts it at the frame origin. All outputs depend combinationally on the counter state of the current cycle and on the current `en` and `rgbIn`.

Top module: `vtg_top`

## Requirements
- R1: The configuration inputs are copied into the working geometry only in the cycle after `rst` is high, or after an enabled step that wraps both counters to the origin. A configuration change at any other time has no effect on the outputs until then.
- R2: Each enabled clock advances the horizontal counter `h`. When `h` equals frame width minus 1, `h` returns to 0 and the vertical counter `v` advances. When `v` also equals frame height minus 1, `v` returns to 0.
- R3: With blank widths `hb = frameW - activeW` and `vb = frameH - activeH`, `de` is high exactly when `en` is high, `h >= hb` and `v >= vb`.
- R4: While `en` is low, the counters hold their values, and `de`, `preamble` and `guard` are low. Each sync output sits at its idle level, which is its polarity bit.
- R5: `rgbOut` equals `rgbIn` while `de` is high and is all zeros otherwise.
- R6: On rows with `v >= vb` and with `en` high, `guard` is high for `h` in `[hb-2, hb-1]`, and `preamble` is high for `h` in `[hb-10, hb-3]`. On other rows both are low. The horizontal blank must be at least 10 cycles.
- R7: `rst` high at a clock edge sets both counters to 0 and loads the configuration, whatever `en` is.
- R8: While `de` is high, `posX = h - hb` and `posY = v - vb`. Otherwise both are 0.
- R9: The raw hsync is active when `en` is high and `h` lies in `[hsStart, hsStart + hsWidth)`. `hsync` equals raw XOR `cfgHsPol`, so polarity 1 means the pulse is active-low. `vsync` follows the same rule on `v` with its own start, width and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous restart to frame origin, active high |
| en | input | 1 | Raster advance enable; low freezes and blanks |
| cfgFrameW | input | CW | Total pixels per line |
| cfgFrameH | input | CW | Total lines per frame |
| cfgActW | input | CW | Active pixels per line |
| cfgActH | input | CW | Active lines per frame |
| cfgHsStart | input | CW | Horizontal position where hsync begins |
| cfgHsWidth | input | CW | Hsync length in pixels |
| cfgHsPol | input | 1 | Hsync polarity, 1 = active-low |
| cfgVsStart | input | CW | Line where vsync begins |
| cfgVsWidth | input | CW | Vsync length in lines |
| cfgVsPol | input | 1 | Vsync polarity, 1 = active-low |
| rgbIn | input | 3*BPC | Incoming pixel |
| rgbOut | output | 3*BPC | Pixel gated by data-enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable, high on active pixels |
| preamble | output | 1 | Preamble window before active pixels |
| guard | output | 1 | Guard window just before active pixels |
| posX | output | CW | Column within the active picture |
| posY | output | CW | Row within the active picture |

## Verification
The hardest case to reach is a configuration write that lands in the middle of a frame and is then followed by a disabled cycle at the exact wrap point. The shadow load must wait for the enabled wrap step, not for the cycle in which the counters reach their end values. The bench writes a fresh random geometry at random moments throughout long runs in which `en` drops on about a fifth of the cycles. Its reference model commits new geometry only at the modelled wrap. Any early or late load therefore shows up as a mismatch in `de`, the strobes or the positions on the following frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Per-cycle step commands issued by the control to the datapath.
  typedef struct packed {
    logic live;     // raster running this cycle
    logic restart;  // return to origin
    logic stepH;    // advance horizontal position
    logic wrapH;    // horizontal counter returns to zero
    logic wrapV;    // vertical counter returns to zero
    logic loadCfg;  // copy configuration into shadow
  } vtgStep_t;

endpackage

// File: rtl/vtg_sync.sv
module vtg_sync #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] width,
  input  logic          pol,
  input  logic          live,
  output logic          syncOut
);

  logic [CW:0] stopPos;
  logic        inWin;

  always_comb begin
    stopPos = {1'b0, start} + {1'b0, width};
    inWin   = (cnt >= start) && ({1'b0, cnt} < stopPos);
    syncOut = (live & inWin) ^ pol;
  end

endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic     rst,
  input  logic     en,
  input  logic     atLineEnd,
  input  logic     atFrameEnd,
  output vtgStep_t step
);

  always_comb begin
    step         = '0;
    step.live    = en;
    step.restart = rst;
    step.stepH   = en & ~rst;
    step.wrapH   = step.stepH & atLineEnd;
    step.wrapV   = step.wrapH & atFrameEnd;
    step.loadCfg = rst | step.wrapV;
  end

endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int CW        = 12,
  parameter int PW        = 24,
  parameter int GUARD_LEN = 2,
  parameter int PRE_LEN   = 8
) (
  input  logic          clk,
  input  vtgStep_t      step,
  input  logic [CW-1:0] cfgFrameW,
  input  logic [CW-1:0] cfgFrameH,
  input  logic [CW-1:0] cfgActW,
  input  logic [CW-1:0] cfgActH,
  input  logic [CW-1:0] cfgHsStart,
  input  logic [CW-1:0] cfgHsWidth,
  input  logic          cfgHsPol,
  input  logic [CW-1:0] cfgVsStart,
  input  logic [CW-1:0] cfgVsWidth,
  input  logic          cfgVsPol,
  input  logic [PW-1:0] rgbIn,
  output logic          atLineEnd,
  output logic          atFrameEnd,
  output logic [PW-1:0] rgbOut,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          preamble,
  output logic          guard,
  output logic [CW-1:0] posX,
  output logic [CW-1:0] posY
);

  localparam logic [CW:0] GUARD_OFS = (CW+1)'(GUARD_LEN);
  localparam logic [CW:0] LEAD_OFS  = (CW+1)'(GUARD_LEN + PRE_LEN);

  // shadow geometry
  logic [CW-1:0] frameW, frameH, actW, actH;
  logic [1:0][CW-1:0] syncStart, syncWidth;
  logic [1:0]         syncPol;

  always_ff @(posedge clk) begin
    if (step.loadCfg) begin
      frameW       <= cfgFrameW;
      frameH       <= cfgFrameH;
      actW         <= cfgActW;
      actH         <= cfgActH;
      syncStart[0] <= cfgHsStart;
      syncWidth[0] <= cfgHsWidth;
      syncPol[0]   <= cfgHsPol;
      syncStart[1] <= cfgVsStart;
      syncWidth[1] <= cfgVsWidth;
      syncPol[1]   <= cfgVsPol;
    end
  end

  // position counters
  logic [CW-1:0] hCnt, vCnt;

  always_ff @(posedge clk) begin
    if (step.restart) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (step.stepH) begin
      if (step.wrapH) begin
        hCnt <= '0;
        vCnt <= step.wrapV ? '0 : vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  assign atLineEnd  = (hCnt == frameW - 1'b1);
  assign atFrameEnd = (vCnt == frameH - 1'b1);

  // region decode
  logic [CW:0] hBlank, vBlank, hExt, vExt;
  logic        rowAct, colAct;

  always_comb begin
    hBlank   = {1'b0, frameW} - {1'b0, actW};
    vBlank   = {1'b0, frameH} - {1'b0, actH};
    hExt     = {1'b0, hCnt};
    vExt     = {1'b0, vCnt};
    rowAct   = vExt >= vBlank;
    colAct   = hExt >= hBlank;
    de       = step.live & rowAct & colAct;
    guard    = step.live & rowAct & (hExt + GUARD_OFS >= hBlank) & (hExt < hBlank);
    preamble = step.live & rowAct & (hExt + LEAD_OFS >= hBlank) & (hExt + GUARD_OFS < hBlank);
    posX     = de ? hCnt - hBlank[CW-1:0] : '0;
    posY     = de ? vCnt - vBlank[CW-1:0] : '0;
    rgbOut   = de ? rgbIn : '0;
  end

  // sync pulse generators, one per axis
  logic [1:0][CW-1:0] axCnt;
  logic [1:0]         axSync;

  assign axCnt[0] = hCnt;
  assign axCnt[1] = vCnt;

  for (genvar a = 0; a < 2; a++) begin : gSync
    vtg_sync #(.CW(CW)) uSync (
      .cnt    (axCnt[a]),
      .start  (syncStart[a]),
      .width  (syncWidth[a]),
      .pol    (syncPol[a]),
      .live   (step.live),
      .syncOut(axSync[a])
    );
  end

  assign hsync = axSync[0];
  assign vsync = axSync[1];

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int CW        = 12,
  parameter int BPC       = 8,
  parameter int GUARD_LEN = 2,
  parameter int PRE_LEN   = 8,
  localparam int PW       = 3 * BPC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cfgFrameW,
  input  logic [CW-1:0] cfgFrameH,
  input  logic [CW-1:0] cfgActW,
  input  logic [CW-1:0] cfgActH,
  input  logic [CW-1:0] cfgHsStart,
  input  logic [CW-1:0] cfgHsWidth,
  input  logic          cfgHsPol,
  input  logic [CW-1:0] cfgVsStart,
  input  logic [CW-1:0] cfgVsWidth,
  input  logic          cfgVsPol,
  input  logic [PW-1:0] rgbIn,
  output logic [PW-1:0] rgbOut,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          preamble,
  output logic          guard,
  output logic [CW-1:0] posX,
  output logic [CW-1:0] posY
);

  vtgStep_t step;
  logic     atLineEnd, atFrameEnd;

  vtg_ctrl uCtrl (
    .rst       (rst),
    .en        (en),
    .atLineEnd (atLineEnd),
    .atFrameEnd(atFrameEnd),
    .step      (step)
  );

  vtg_datapath #(
    .CW(CW), .PW(PW), .GUARD_LEN(GUARD_LEN), .PRE_LEN(PRE_LEN)
  ) uDp (
    .clk       (clk),
    .step      (step),
    .cfgFrameW (cfgFrameW),
    .cfgFrameH (cfgFrameH),
    .cfgActW   (cfgActW),
    .cfgActH   (cfgActH),
    .cfgHsStart(cfgHsStart),
    .cfgHsWidth(cfgHsWidth),
    .cfgHsPol  (cfgHsPol),
    .cfgVsStart(cfgVsStart),
    .cfgVsWidth(cfgVsWidth),
    .cfgVsPol  (cfgVsPol),
    .rgbIn     (rgbIn),
    .atLineEnd (atLineEnd),
    .atFrameEnd(atFrameEnd),
    .rgbOut    (rgbOut),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .preamble  (preamble),
    .guard     (guard),
    .posX      (posX),
    .posY      (posY)
  );

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [PW-1:0] rgbOut,
  input logic          de,
  input logic          preamble,
  input logic          guard,
  input logic [CW-1:0] posX,
  input logic [CW-1:0] posY
);

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    !de |-> rgbOut == '0); // R5

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |-> !de && !preamble && !guard); // R4

  AST_WINDOW_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({de, preamble, guard})); // R6

  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    de && $past(de) && $past(en) && !$past(rst) |-> posX == $past(posX) + 1'b1); // R8

  AST_ROW_KEEP: assert property (@(posedge clk) disable iff (rst)
    de && $past(de) && $past(en) && !$past(rst) |-> posY == $past(posY)); // R2

  AST_GUARD_LEADS: assert property (@(posedge clk) disable iff (rst)
    $past(guard) && $past(en) && en && !$past(rst) |-> guard || de); // R6

endmodule

bind vtg_top vtg_chk #(.CW(CW), .PW(PW)) uChk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .rgbOut  (rgbOut),
  .de      (de),
  .preamble(preamble),
  .guard   (guard),
  .posX    (posX),
  .posY    (posY)
);

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
  localparam int CW = 12;
  localparam int BPC = 8;
  localparam int PW = 3 * BPC;

  logic          clk = 1'b0;
  logic          rst = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] cfgFrameW = '0, cfgFrameH = '0, cfgActW = '0, cfgActH = '0;
  logic [CW-1:0] cfgHsStart = '0, cfgHsWidth = '0, cfgVsStart = '0, cfgVsWidth = '0;
  logic          cfgHsPol = 1'b0, cfgVsPol = 1'b0;
  logic [PW-1:0] rgbIn = '0;
  logic [PW-1:0] rgbOut;
  logic          hsync, vsync, de, preamble, guard;
  logic [CW-1:0] posX, posY;

  vtg_top #(.CW(CW), .BPC(BPC)) u0 (
    .clk(clk), .rst(rst), .en(en),
    .cfgFrameW(cfgFrameW), .cfgFrameH(cfgFrameH), .cfgActW(cfgActW), .cfgActH(cfgActH),
    .cfgHsStart(cfgHsStart), .cfgHsWidth(cfgHsWidth), .cfgHsPol(cfgHsPol),
    .cfgVsStart(cfgVsStart), .cfgVsWidth(cfgVsWidth), .cfgVsPol(cfgVsPol),
    .rgbIn(rgbIn), .rgbOut(rgbOut), .hsync(hsync), .vsync(vsync), .de(de),
    .preamble(preamble), .guard(guard), .posX(posX), .posY(posY)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // written configuration and committed (model) configuration
  int cFw, cFh, cAw, cAh, cHs, cHw, cVs, cVw;
  bit cHp, cVp;
  int sFw, sFh, sAw, sAh, sHs, sHw, sVs, sVw;
  bit sHp, sVp;
  int mH, mV;
  bit started = 0, pend = 0, prevRst = 0;

  task automatic chk(input string ctx, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s h=%0d v=%0d actual=%0d expected=%0d", ctx, what, mH, mV, act, exp);
    end
  endtask

  task automatic drivecfg();
    cfgFrameW = CW'(cFw); cfgFrameH = CW'(cFh); cfgActW = CW'(cAw); cfgActH = CW'(cAh);
    cfgHsStart = CW'(cHs); cfgHsWidth = CW'(cHw); cfgHsPol = cHp;
    cfgVsStart = CW'(cVs); cfgVsWidth = CW'(cVw); cfgVsPol = cVp;
    pend = 1;
  endtask

  task automatic newCfg();
    int hb, vb;
    cFw = 24 + int'($urandom % 20);
    hb  = 10 + int'($urandom % 6);
    cAw = cFw - hb;
    cFh = 5 + int'($urandom % 6);
    vb  = 1 + int'($urandom % 3);
    cAh = cFh - vb;
    cHs = int'($urandom % 32'(hb));
    cHw = 1 + int'($urandom % 4);
    cVs = int'($urandom % 32'(vb));
    cVw = 1 + int'($urandom % 2);
    cHp = 1'($urandom);
    cVp = 1'($urandom);
    drivecfg();
  endtask

  task automatic commit();
    sFw = cFw; sFh = cFh; sAw = cAw; sAh = cAh;
    sHs = cHs; sHw = cHw; sHp = cHp; sVs = cVs; sVw = cVw; sVp = cVp;
    pend = 0;
  endtask

  task automatic checkOuts();
    int hb, vb;
    bit rowA, eDe, eGuard, ePre, eHs, eVs;
    string ctx;
    hb = sFw - sAw;
    vb = sFh - sAh;
    rowA = (mV >= vb);
    eDe = en && rowA && (mH >= hb);
    eGuard = en && rowA && (mH + 2 >= hb) && (mH < hb);
    ePre = en && rowA && (mH + 10 >= hb) && (mH + 2 < hb);
    eHs = (en && mH >= sHs && mH < sHs + sHw) ^ sHp;
    eVs = (en && mV >= sVs && mV < sVs + sVw) ^ sVp;
    ctx = prevRst ? "R7" : (!en ? "R4" : (pend ? "R1" : "R2"));
    chk(ctx, "R3 de", longint'(de), longint'(eDe));
    chk(ctx, "R5 rgbOut", longint'(rgbOut), eDe ? longint'(rgbIn) : 0);
    chk(ctx, "R6 guard", longint'(guard), longint'(eGuard));
    chk(ctx, "R6 preamble", longint'(preamble), longint'(ePre));
    chk(ctx, "R9 hsync", longint'(hsync), longint'(eHs));
    chk(ctx, "R9 vsync", longint'(vsync), longint'(eVs));
    chk(ctx, "R8 posX", longint'(posX), eDe ? longint'(mH - hb) : 0);
    chk(ctx, "R8 posY", longint'(posY), eDe ? longint'(mV - vb) : 0);
  endtask

  task automatic advance();
    prevRst = rst;
    if (rst) begin
      mH = 0; mV = 0; commit(); started = 1;
    end else if (en) begin
      if (mH == sFw - 1) begin
        mH = 0;
        if (mV == sFh - 1) begin mV = 0; commit(); end
        else mV++;
      end else begin
        mH++;
      end
    end
  endtask

  task automatic step(input int enPct, input int rstPermil, input bit forceRst);
    @(negedge clk);
    rst = forceRst || (int'($urandom % 1000) < rstPermil);
    en = int'($urandom % 100) < enPct;
    rgbIn = PW'($urandom);
    #1;
    if (started) checkOuts();
    @(posedge clk);
    advance();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed: first geometry, reset, two clean frames (R7, R2, R3, R6)
    newCfg();
    step(100, 0, 1);
    repeat (2 * cFw * cFh + 5) step(100, 0, 0);
    // directed: long freeze (R4)
    repeat (40) step(0, 0, 0);
    // directed: new geometry written mid-frame, held until wrap (R1)
    repeat (7) step(100, 0, 0);
    newCfg();
    repeat (2 * 44 * 10) step(100, 0, 0);
    // directed: reset with en low still restarts (R7)
    step(0, 0, 1);
    repeat (20) step(100, 0, 0);
    // random: geometry rewritten at random moments, en drops, rare resets
    for (int i = 0; i < 24; i++) begin
      repeat (int'($urandom % 400)) step(80, 2, 0);
      newCfg();
      repeat (500) step(80, 2, 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule